// File: doc/BRIEF.md
# Dual-Target Masked Interrupt Aggregator

This block gathers up to 32 level-sensitive interrupt requests from on-board peripherals. Each request passes through a two-flop synchroniser into a status word that software can read. Four enable masks, two for ordinary interrupts and two for machine checks, gate that status word. Each mask feeds one output line, so any pending source can be sent to either of two processor cores as an ordinary interrupt, a machine check, or both.

Nothing prevents one source from being enabled in several masks, so one request can raise several outputs in the same cycle. There is no acknowledge path. A status bit clears only when the source device lowers its request.

A further read-only word reports the highest-numbered source that is both pending and enabled in the core-0 ordinary mask. An interrupt handler can use it to pick a source without scanning the status word. Software reaches all registers over a single-cycle 32-bit register bus. The bus uses byte addresses, is decoded on word boundaries, and ignores address bits [1:0].

Top module: `irq_aggregator`

## Requirements
- R1: After reset all four mask words are zero, every output is low, and the highest-pending word reads zero.
- R2: A read at offset 0x000 returns the status word. Status bit i is 1 when input i has been high for at least two clock edges.
- R3: Status bits 6 and 17 to 31 are reserved. They always read zero, and the matching inputs never assert any output.
- R4: The mask words sit at these offsets and read back what was last written: 0x010 for ordinary core 0, 0x014 for ordinary core 1, 0x018 for machine-check core 0, and 0x01C for machine-check core 1. A mask bit of 1 enables its source.
- R5: Each output is high whenever status AND its mask is non-zero. A source rising or falling while enabled changes the output on the third clock edge after the input change. Outputs stay high as long as the source stays high, and no register clears them.
- R6: One source enabled in several masks asserts all the matching outputs at the same time.
- R7: A read at offset 0x020 returns {1, 26 zeros, index} when status AND the core-0 ordinary mask is non-zero. Here index is the 5-bit number of the highest set bit. The read returns 0 when that AND is zero.
- R8: Writes to 0x000, to 0x020 and to unmapped offsets change no register. Reads of unmapped offsets return zero.
- R9: A write takes effect at the clock edge that samples the write strobe. Read data appears one cycle after the read strobe and is zero in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level interrupt requests, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 2 | Ordinary interrupt per core |
| mchk_o | output | 2 | Machine-check per core |

## Verification
The directed patterns cover these cases:
- All inputs high with all masks open, which separates live status bits from reserved ones.
- A single source with a single mask bit, which pins the three-edge rise and fall latency.
- One source open in all four masks, which shows the outputs are not exclusive.
- Several sources under a partial core-0 mask, which shows that the highest-index report follows the masked AND and not raw status.

Random input words and random mask words are then compared against a reference model of status, the four outputs and the highest-pending word. This separates errors in mask steering from errors in reduction. Writes to read-only and unmapped offsets, followed by readback, show that no stray decode reaches a mask.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
    localparam int DW       = 32;
    localparam int NOUT     = 4;   // 0,1 ordinary core0/1; 2,3 machine-check core0/1
    localparam int ADDR_W   = 8;
    localparam int WIX_W    = ADDR_W - 2;
    localparam int IDX_W    = $clog2(DW);

    localparam logic [WIX_W-1:0] WIX_STATUS = WIX_W'(0);
    localparam logic [WIX_W-1:0] WIX_MASK0  = WIX_W'(4);   // masks occupy 4..7
    localparam logic [WIX_W-1:0] WIX_TOPSRC = WIX_W'(8);

    localparam logic [DW-1:0] RSVD_BITS = 32'hFFFE_0040;

    typedef struct packed {
        logic [NOUT-1:0][DW-1:0] mask;
        logic [NOUT-1:0]         out;
        logic [DW-1:0]           rdata;
    } agg_state_t;
endpackage

// File: rtl/intagg_sync.sv
module intagg_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/intagg_prio.sv
module intagg_prio #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import intagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     src_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [1:0]        irq_o,
    output logic [1:0]        mchk_o
);
    agg_state_t st_d, st_q;

    logic [DW-1:0]    synced;
    logic [DW-1:0]    status;
    logic             top_any;
    logic [IDX_W-1:0] top_idx;
    logic [WIX_W-1:0] widx;

    intagg_sync #(.W(DW), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (synced)
    );

    assign status = synced & ~RSVD_BITS;
    assign widx   = bus_addr[ADDR_W-1:2];

    intagg_prio #(.W(DW), .IDX_W(IDX_W)) u_prio (
        .req_i (status & st_q.mask[0]),
        .any_o (top_any),
        .idx_o (top_idx)
    );

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NOUT; k++) begin
            st_d.out[k] = |(status & st_q.mask[k]);
            if (bus_wr && widx == WIX_MASK0 + WIX_W'(k))
                st_d.mask[k] = bus_wdata;
        end
        st_d.rdata = '0;
        if (bus_rd) begin
            if (widx == WIX_STATUS)
                st_d.rdata = status;
            else if (widx == WIX_TOPSRC)
                st_d.rdata = {top_any, {(DW-1-IDX_W){1'b0}}, top_idx};
            for (int k = 0; k < NOUT; k++)
                if (widx == WIX_MASK0 + WIX_W'(k))
                    st_d.rdata = st_q.mask[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq_o     = st_q.out[1:0];
    assign mchk_o    = st_q.out[3:2];

    // R1: a closed core-0 ordinary mask keeps its line low on the next cycle
    a_r1_closed_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask[0] == '0) |=> !irq_o[0]);

    // R3: a status read never shows reserved positions
    a_r3_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && widx == WIX_STATUS) |=> ((bus_rdata & RSVD_BITS) == '0));

    // R4: a mask write is visible in the mask word at the next cycle
    a_r4_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == WIX_MASK0) |=> (st_q.mask[0] == $past(bus_wdata)));

    // R7: the highest-pending word has only its flag and index bits in use
    a_r7_top_format: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && widx == WIX_TOPSRC) |=> (bus_rdata[DW-2:IDX_W] == '0));

    // R8: a read of an unmapped word returns zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && widx != WIX_STATUS && widx != WIX_TOPSRC &&
         (widx < WIX_MASK0 || widx > WIX_MASK0 + WIX_W'(3))) |=> (bus_rdata == '0));

    // R9: no read strobe gives zero read data
    a_r9_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;
    logic [1:0]  mchk_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] mdl_mask [4];

    localparam logic [31:0] RSVD = 32'hFFFE_0040;

    irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .mchk_o(mchk_o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] exp_status(input logic [31:0] s);
        return s & ~RSVD;
    endfunction

    function automatic logic [3:0] exp_outs(input logic [31:0] s);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = |(exp_status(s) & mdl_mask[k]);
        return r;
    endfunction

    function automatic logic [31:0] exp_top(input logic [31:0] s);
        logic [31:0] v = exp_status(s) & mdl_mask[0];
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) if (v[i]) r = 32'h8000_0000 | 32'(i);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a >= 8'h10 && a <= 8'h1C && a[1:0] == 2'b00) mdl_mask[(a - 8'h10) >> 2] = d;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        check(req, {28'b0, mchk_o, irq_o}, {28'b0, exp_outs(src_i)});
        bus_read(8'h00, d); check(req, d, exp_status(src_i));
        bus_read(8'h20, d); check(req, d, exp_top(src_i));
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        for (int k = 0; k < 4; k++) mdl_mask[k] = '0;
        settle(4);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        check("R1", {28'b0, mchk_o, irq_o}, 32'h0);
        for (int k = 0; k < 4; k++) begin
            bus_read(8'(8'h10 + 4 * k), d); check("R1", d, 32'h0);
        end
        bus_read(8'h20, d); check("R1", d, 32'h0);

        // R4 / R9 mask readback, read straight after write
        bus_write(8'h10, 32'h1111_0001);
        bus_read(8'h10, d); check("R9", d, 32'h1111_0001);
        bus_write(8'h14, 32'h2222_0002);
        bus_write(8'h18, 32'h4444_0004);
        bus_write(8'h1C, 32'h8888_0008);
        for (int k = 0; k < 4; k++) begin
            bus_read(8'(8'h10 + 4 * k), d); check("R4", d, mdl_mask[k]);
        end

        // R8 writes to read-only and unmapped words are ignored
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_write(8'hFC, 32'hFFFF_FFFF);
        for (int k = 0; k < 4; k++) begin
            bus_read(8'(8'h10 + 4 * k), d); check("R8", d, mdl_mask[k]);
        end
        bus_read(8'h24, d); check("R8", d, 32'h0);
        bus_read(8'h04, d); check("R8", d, 32'h0);
        bus_read(8'hFC, d); check("R8", d, 32'h0);
        bus_read(8'h00, d); check("R8", d, 32'h0);

        // R2 / R3 all inputs high, all masks open
        for (int k = 0; k < 4; k++) bus_write(8'(8'h10 + 4 * k), 32'hFFFF_FFFF);
        @(negedge clk); src_i = 32'hFFFF_FFFF;
        settle(3);
        bus_read(8'h00, d); check("R2", d, 32'h0001_FFBF);
        bus_read(8'h20, d); check("R7", d, 32'h8000_0010);
        // R3 only reserved inputs high
        @(negedge clk); src_i = 32'h0010_0040;
        settle(4);
        check("R3", {28'b0, mchk_o, irq_o}, 32'h0);
        bus_read(8'h00, d); check("R3", d, 32'h0);

        // R5 latency: rise and fall on the third edge
        @(negedge clk); src_i = '0;
        for (int k = 0; k < 4; k++) bus_write(8'(8'h10 + 4 * k), 32'h0);
        bus_write(8'h10, 32'h0000_0008);
        settle(3);
        src_i = 32'h0000_0008;
        settle(2); check("R5", {31'b0, irq_o[0]}, 32'h0);
        settle(1); check("R5", {31'b0, irq_o[0]}, 32'h1);
        settle(5); check("R5", {31'b0, irq_o[0]}, 32'h1);
        src_i = '0;
        settle(2); check("R5", {31'b0, irq_o[0]}, 32'h1);
        settle(1); check("R5", {31'b0, irq_o[0]}, 32'h0);

        // R6 one source on every output
        for (int k = 0; k < 4; k++) bus_write(8'(8'h10 + 4 * k), 32'h0000_0020);
        @(negedge clk); src_i = 32'h0000_0020;
        settle(4);
        check("R6", {28'b0, mchk_o, irq_o}, 32'hF);

        // R7 highest pending follows the masked AND, not raw status
        bus_write(8'h10, 32'h0000_0F0F);
        @(negedge clk); src_i = 32'h0001_0E01;
        settle(4);
        bus_read(8'h20, d); check("R7", d, 32'h8000_000B);
        bus_write(8'h10, 32'h0);
        bus_read(8'h20, d); check("R7", d, 32'h0);

        // random mix
        for (int it = 0; it < 150; it++) begin
            if ($urandom_range(0, 3) == 0) begin
                int k = $urandom_range(0, 3);
                logic [31:0] m = $urandom();
                if ($urandom_range(0, 1) == 1) m = m & $urandom();
                bus_write(8'(8'h10 + 4 * k), m);
            end
            @(negedge clk);
            src_i = $urandom() & $urandom();
            settle(4);
            check_all("R5 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule